// File: doc/BRIEF.md
# Parallel Port Test FIFO

This block is the byte-wide FIFO register slice of an extended-capability parallel port, limited to its software test mode. A host bus reaches three byte registers through a two-bit register select. A mode field in the extended control register decides what the data location means. In test mode it is a FIFO that software can write and read in any order. In configuration mode the data location and its neighbour return two read-only configuration bytes. In test mode the byte at the head of the FIFO is also shown on the port data lines, so software can watch it.

The FIFO never stalls on misuse. A write to a full FIFO is dropped. A read from an empty FIFO returns the byte read before it again. Full and empty always report the true occupancy. A level-type service interrupt reports a threshold, and the direction bit flips its meaning. With the direction bit at 0 it marks a FIFO that has drained down to the write threshold. With the direction bit at 1 it marks a FIFO that has filled up to the read threshold. Software can find the depth and both thresholds by filling or draining the FIFO one byte at a time. Each time the mode field changes, the FIFO is emptied.

Top module: `ptf_top`

## Requirements
- R1: Register select 2 is the extended control register. On a write, bits 7:5 set the mode and bit 4 sets the direction. On a read it returns {mode, dir, 2'b00, full, empty}. Reset leaves mode 3'b000 and dir 0. At select 0 the FIFO is reached only when mode is 3'b110. At select 0 with mode 3'b000 a read returns 0x00.
- R2: In mode 3'b110 a read at select 0 returns the head byte and then removes it, so bytes come back in the order they were written whatever the direction bit is. The port data output shows the same value in mode 3'b110 and shows 0x00 in any other mode.
- R3: A FIFO write that arrives while the FIFO is full is discarded. Occupancy and contents do not change and full stays 1.
- R4: A FIFO read that arrives while the FIFO is empty returns the last byte that was removed (0x00 if none has been removed since reset). It changes nothing, and empty stays 1.
- R5: Empty is 1 exactly when occupancy is 0 and full is 1 exactly when occupancy equals DEPTH. After reset empty is 1 and full is 0.
- R6: In mode 3'b110 with dir 0, service_irq is 1 exactly when occupancy is at most WR_THR. With dir 1 it is 1 exactly when occupancy is at least RD_THR. In any other mode it is 0.
- R7: When a read and a write arrive in the same cycle, the read takes the current head, or the last byte if the FIFO is empty. The write is accepted unless the FIFO was full beforehand. With a FIFO that is neither empty nor full, the occupancy is unchanged.
- R8: In mode 3'b111 a read at select 0 returns 0x10. Writes at select 0 or 1 in that mode have no effect.
- R9: In mode 3'b111 a read at select 1 returns {1'b0, service_irq, IRQ_CODE[2:0], DMA_CODE[2:0]}.
- R10: A control-register write that changes the mode field empties the FIFO in that cycle. A write that keeps the same mode, for example one that changes only the direction bit, leaves the contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 data, 1 configuration B, 2 extended control |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register (removes a FIFO byte) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| service_irq | output | 1 | Threshold service interrupt |
| port_data | output | 8 | Port data lines showing the head byte in test mode |

## Verification
A FIFO read and a FIFO write can land in the same cycle because the two strobes are separate. The bench raises both strobes together on an empty FIFO, a partly filled FIFO and a full FIFO. It judges each case against a byte-queue model: the byte returned, whether the write was accepted, and the order of the bytes drained afterwards. A write that only flips the direction bit on a full FIFO is used to show that the contents survive. A change of mode is used to show that the FIFO is emptied.

// File: rtl/ptf_pkg.sv
// Package: shared constants for the parallel port test FIFO slice.
// Assumes an 8-bit data path and a 2-bit register select.
package ptf_pkg;
    localparam int BYTE_W = 8;

    // Register select codes
    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CFGB = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Mode field codes
    localparam logic [2:0] MODE_TEST = 3'b110;
    localparam logic [2:0] MODE_CFG  = 3'b111;

    // Configuration A constant: 8-bit implementation
    localparam logic [BYTE_W-1:0] CFGA_VALUE = 8'h10;

    // Builds the configuration B byte from its fields.
    function automatic logic [BYTE_W-1:0] cfgb_byte(input logic irq_now,
                                                    input logic [2:0] irq_code,
                                                    input logic [2:0] dma_code);
        return {1'b0, irq_now, irq_code, dma_code};
    endfunction
endpackage

// File: rtl/ptf_fifo_store.sv
// Module: FIFO storage with occupancy count. Drops pushes when full,
// ignores pops when empty, flush has priority over both.
// Assumes push and pop are already qualified by mode and select.
module ptf_fifo_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [W-1:0]  push_data,
    output logic [W-1:0]  head,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty
);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    // Qualify requests with the current occupancy
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Store accepted bytes
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                occ <= occ + 1'b1;
            end else if (do_pop && !do_push) begin
                occ <= occ - 1'b1;
            end
        end
    end

    // Flags and head byte from the registered state
    always_comb begin
        full  = (occ == FULL_CNT);
        empty = (occ == '0);
        head  = mem[rd_ptr];
    end
endmodule

// File: rtl/ptf_ctrl_reg.sv
// Module: extended control register holding mode and direction.
// Raises a flush pulse in the cycle a write changes the mode field.
// Assumes wr is already qualified by the control select.
module ptf_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [2:0] mode,
    output logic       dir,
    output logic       flush
);
    // Detect a mode change on write
    always_comb begin
        flush = wr && (wdata[7:5] != mode);
    end

    // Hold mode and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 3'b000;
            dir  <= 1'b0;
        end else if (wr) begin
            mode <= wdata[7:5];
            dir  <= wdata[4];
        end
    end
endmodule

// File: rtl/ptf_irq_gen.sv
// Module: level service interrupt from occupancy and direction.
// Assumes thresholds lie within 0..DEPTH.
module ptf_irq_gen #(
    parameter int CW     = 5,
    parameter int WR_THR = 8,
    parameter int RD_THR = 8
) (
    input  logic [CW-1:0] occ,
    input  logic          dir,
    input  logic          test_mode,
    output logic          service_irq
);
    localparam logic [CW-1:0] WR_T = CW'(WR_THR);
    localparam logic [CW-1:0] RD_T = CW'(RD_THR);

    // Pick the threshold comparison by direction
    always_comb begin
        if (!test_mode) begin
            service_irq = 1'b0;
        end else if (dir) begin
            service_irq = (occ >= RD_T);
        end else begin
            service_irq = (occ <= WR_T);
        end
    end
endmodule

// File: rtl/ptf_top.sv
// Module: parallel port test FIFO slice. Decodes register select and
// mode, routes FIFO accesses, returns configuration bytes, drives the
// head byte to the port lines. Assumes one register select per cycle.
module ptf_top #(
    parameter int DEPTH    = 16,
    parameter int WR_THR   = DEPTH / 2,
    parameter int RD_THR   = DEPTH / 2,
    parameter int IRQ_CODE = 5,
    parameter int DMA_CODE = 3,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       fifo_full,
    output logic       fifo_empty,
    output logic       service_irq,
    output logic [7:0] port_data
);
    import ptf_pkg::*;

    logic [2:0]    mode;
    logic          dir;
    logic          flush;
    logic          test_mode;
    logic          fifo_wr, fifo_rd, ctrl_wr;
    logic [7:0]    head;
    logic [7:0]    last_rd;
    logic [7:0]    fifo_view;
    logic [CW-1:0] occ;

    // Decode accesses from select and mode
    always_comb begin
        test_mode = (mode == MODE_TEST);
        fifo_wr   = wr_en && (reg_sel == SEL_DATA) && test_mode;
        fifo_rd   = rd_en && (reg_sel == SEL_DATA) && test_mode;
        ctrl_wr   = wr_en && (reg_sel == SEL_CTRL);
    end

    ptf_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wdata (wr_data),
        .mode  (mode),
        .dir   (dir),
        .flush (flush)
    );

    ptf_fifo_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_wr),
        .pop       (fifo_rd),
        .flush     (flush),
        .push_data (wr_data),
        .head      (head),
        .occ       (occ),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    ptf_irq_gen #(.CW(CW), .WR_THR(WR_THR), .RD_THR(RD_THR)) u_irq (
        .occ         (occ),
        .dir         (dir),
        .test_mode   (test_mode),
        .service_irq (service_irq)
    );

    // Remember the last byte removed, for underflow reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd <= '0;
        end else if (fifo_rd && !fifo_empty) begin
            last_rd <= head;
        end
    end

    // Value seen at the data location in test mode
    always_comb begin
        fifo_view = fifo_empty ? last_rd : head;
    end

    // Read data multiplexer
    always_comb begin
        rd_data = '0;
        unique case (reg_sel)
            SEL_DATA: begin
                if (test_mode)            rd_data = fifo_view;
                else if (mode == MODE_CFG) rd_data = CFGA_VALUE;
            end
            SEL_CFGB: begin
                if (mode == MODE_CFG)
                    rd_data = cfgb_byte(service_irq, 3'(IRQ_CODE), 3'(DMA_CODE));
            end
            SEL_CTRL: rd_data = {mode, dir, 2'b00, fifo_full, fifo_empty};
            default:  rd_data = '0;
        endcase
    end

    // Port data lines display the FIFO in test mode
    always_comb begin
        port_data = test_mode ? fifo_view : 8'h00;
    end
endmodule

// File: rtl/ptf_checker.sv
// Module: assertion checker for ptf_top, attached by bind.
// Assumes it sees the top's internal decode and occupancy signals.
module ptf_checker #(
    parameter int CW     = 5,
    parameter int RD_THR = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic          fifo_wr,
    input logic          fifo_rd,
    input logic          service_irq,
    input logic          dir,
    input logic [2:0]    mode,
    input logic [CW-1:0] occ
);
    // R5: flags never both set
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R3: dropped write keeps full and occupancy
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && fifo_wr && !fifo_rd) |=> (fifo_full && $stable(occ)));

    // R4: underflow read leaves the FIFO empty
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && fifo_rd && !fifo_wr) |=> fifo_empty);

    // R7: simultaneous access on a middle occupancy keeps the count
    p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_empty && !fifo_full && fifo_wr && fifo_rd) |=> $stable(occ));

    // R10: a mode change leaves the FIFO empty
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> fifo_empty);

    // R6: filling direction, reading at threshold drops the interrupt
    p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && service_irq && fifo_rd && !fifo_wr && occ == CW'(RD_THR)
         && $stable(mode)) |=> !service_irq);
endmodule

bind ptf_top ptf_checker #(.CW(CW), .RD_THR(RD_THR)) u_ptf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .fifo_wr     (fifo_wr),
    .fifo_rd     (fifo_rd),
    .service_irq (service_irq),
    .dir         (dir),
    .mode        (mode),
    .occ         (occ)
);

// File: tb/ptf_top_bench.sv
// Bench: sweeps every occupancy of a depth-8 FIFO in both directions,
// checks overflow, underflow, simultaneous access, config and flush.
module ptf_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int WRT = 3;
    localparam int RDT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, port_data;
    logic       fifo_full, fifo_empty, service_irq;

    int checks = 0, errors = 0;
    logic [7:0] q[$];
    logic [7:0] last_b = 8'h00;
    logic [7:0] got;
    logic       cur_dir = 1'b0;
    logic       in_test = 1'b0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptf_top #(.DEPTH(DEPTH), .WR_THR(WRT), .RD_THR(RDT),
              .IRQ_CODE(5), .DMA_CODE(2)) u_ptf_top (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .service_irq(service_irq), .port_data(port_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle; read data sampled before the capturing edge
    task automatic bus(input logic [1:0] s, input logic w, input logic r,
                       input logic [7:0] d, output logic [7:0] rv);
        @(negedge clk);
        reg_sel = s; wr_en = w; rd_en = r; wr_data = d;
        #1 rv = rd_data;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // FIFO access with model update and read check
    task automatic fifo_op(input logic w, input logic r, input logic [7:0] d,
                           input string req);
        logic [7:0] exp;
        int n;
        n = q.size();
        exp = (n > 0) ? q[0] : last_b;
        bus(2'd0, w, r, d, got);
        if (r) check(req, got, exp);
        if (r && n > 0) begin last_b = q[0]; void'(q.pop_front()); end
        if (w && n < DEPTH) q.push_back(d);
    endtask

    task automatic check_state(input string req);
        int n;
        logic ei;
        n = q.size();
        ei = in_test && (cur_dir ? (n >= RDT) : (n <= WRT));
        check({req, " R5 empty"}, fifo_empty, n == 0);
        check({req, " R5 full"}, fifo_full, n == DEPTH);
        check({req, " R6 irq"}, service_irq, ei);
        if (in_test) check({req, " R2 port"}, port_data, (n > 0) ? q[0] : last_b);
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        logic [7:0] dummy;
        bus(2'd2, 1'b1, 1'b0, v, dummy);
        cur_dir = v[4];
        in_test = (v[7:5] == 3'b110);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // Reset state (R5, R1)
        check_state("reset");
        bus(2'd2, 1'b0, 1'b1, 8'h00, got);
        check("R1 ctrl reset", got, 8'h01);
        bus(2'd0, 1'b0, 1'b1, 8'h00, got);
        check("R1 data mode0", got, 8'h00);
        check("R2 port mode0", port_data, 8'h00);

        // Fill sweep with dir=1 (R6, R5)
        set_ctrl(8'hD0);
        bus(2'd2, 1'b0, 1'b1, 8'h00, got);
        check("R1 ctrl test", got, 8'hD1);
        for (int i = 0; i < DEPTH; i++) begin
            check_state("fill");
            fifo_op(1'b1, 1'b0, 8'(8'h30 + i * 7), "R2 fill");
        end
        check_state("full");
        bus(2'd2, 1'b0, 1'b1, 8'h00, got);
        check("R1 ctrl full", got, 8'hD2);
        // Overflow (R3)
        fifo_op(1'b1, 1'b0, 8'hEE, "R3");
        check("R3 full kept", fifo_full, 1);
        // Same-mode rewrite keeps data (R10)
        set_ctrl(8'hC0);
        check("R10 keep", fifo_full, 1);
        // Drain sweep with dir=0 (R2, R6)
        for (int i = 0; i < DEPTH; i++) begin
            check_state("drain");
            fifo_op(1'b0, 1'b1, 8'h00, "R2 order");
        end
        check_state("drained");
        // Underflow reads (R4)
        for (int i = 0; i < 2; i++) begin
            fifo_op(1'b0, 1'b1, 8'h00, "R4 underflow");
            check_state("R4");
        end
        // Simultaneous access on empty, middle, full (R7)
        fifo_op(1'b1, 1'b1, 8'hA1, "R7 empty both");
        check_state("R7 empty");
        for (int i = 0; i < 3; i++) fifo_op(1'b1, 1'b0, 8'(8'hB0 + i), "R7 pre");
        for (int i = 0; i < 5; i++) begin
            fifo_op(1'b1, 1'b1, 8'(8'hC0 + i), "R7 mid both");
            check_state("R7 mid");
        end
        while (q.size() < DEPTH) fifo_op(1'b1, 1'b0, 8'h5A, "R7 top");
        fifo_op(1'b1, 1'b1, 8'hDD, "R7 full both");
        check_state("R7 full");
        while (q.size() > 0) fifo_op(1'b0, 1'b1, 8'h00, "R7 drain");
        check_state("R7 end");

        // Mode change flushes (R10)
        fifo_op(1'b1, 1'b0, 8'h11, "R10 pre");
        fifo_op(1'b1, 1'b0, 8'h22, "R10 pre");
        set_ctrl(8'hE0);
        q.delete();
        check("R10 flush empty", fifo_empty, 1);
        check("R6 irq off mode7", service_irq, 0);
        check("R2 port mode7", port_data, 8'h00);
        // Configuration registers (R8, R9)
        bus(2'd0, 1'b0, 1'b1, 8'h00, got);
        check("R8 cfgA", got, 8'h10);
        bus(2'd1, 1'b0, 1'b1, 8'h00, got);
        check("R9 cfgB", got, 8'h2A);
        bus(2'd0, 1'b1, 1'b0, 8'hFF, got);
        bus(2'd1, 1'b1, 1'b0, 8'hFF, got);
        bus(2'd0, 1'b0, 1'b1, 8'h00, got);
        check("R8 cfgA after write", got, 8'h10);
        bus(2'd1, 1'b0, 1'b1, 8'h00, got);
        check("R8 cfgB after write", got, 8'h2A);
        // Back to test mode: FIFO empty, old bytes gone (R10)
        set_ctrl(8'hD0);
        check_state("R10 back");
        fifo_op(1'b1, 1'b0, 8'h77, "R10 new");
        fifo_op(1'b0, 1'b1, 8'h00, "R10 first is new");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule